// File: doc/BRIEF.md
# OTP Shadow and Fuse Programming Controller

This block holds a 46-bit one-time-programmable configuration word. A working copy of the word sits in a shadow register. After reset the shadow is filled from the fuse array. Write requests edit the shadow, and the decoded user fields drive the rest of the chip from it. A program request burns the fuses that the shadow asks for. The block issues one single-clock burn pulse per fuse to be set, then refreshes the shadow from the fuses. Two read requests are supported: a digital read that returns the whole fuse word at once, and a readback that streams the fuse bits out one at a time, most significant bit first.

Fuses only ever go from 0 to 1. Bits 45 down to 16 carry factory trim, and no user request can change them. Fuse bit 13 is the lock. Once the lock is burned, bits 15 and 14 can no longer be written or burned. A program request that itself burns the lock also leaves bits 15 and 14 alone.

Requests arrive on a valid/ready channel. The channel accepts a request only while the block is idle. A request presented while the block is busy is not accepted and has no effect, and the requester may withdraw it. The read reply and the readback stream are also valid/ready. The block holds each of them, unchanged, until the consumer takes it. The fuse array sits outside the block. The block sees the fuse state on a parallel input, and drives a pulse and a bit index that the fuse array acts on.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset is released and one load cycle has passed, the outputs are as follows. busy is 0 and cmd_ready is 1. burn_pulse, rsp_valid and rb_valid are all 0. The user-field outputs equal the fuse contents.
- R2: The user fields decode from the shadow word as follows: hall_bias = bits [5:0], offset_hi = bit 6, pga_gain = bits [8:7], cm_cos_en = bit 9, cm_sin_en = bit 10, chan_invert = bit 11.
- R3: A write request (cmd_op = 0) loads cmd_wdata into shadow bits [13:0], and into bits [15:14] when fuse bit 13 is clear. All other shadow bits keep their values. The field outputs change in the cycle after the request is accepted. A write burns nothing.
- R4: A program request (cmd_op = 1) produces exactly one burn_pulse for each bit that meets all three of these conditions: it is 1 in the shadow, it is 0 in the fuses, and it is permitted. Each pulse lasts one clock. Pulses come in ascending bit order. When no bit qualifies, no pulse is produced.
- R5: No burn pulse ever addresses bits [45:16]. The factory bits of the fuse word never change.
- R6: Bits [15:14] are not burned in either of two cases: when fuse bit 13 is already burned, or when the same program request sets shadow bit 13.
- R7: A program request keeps busy high for W+1 = 47 cycles. After that, the shadow and the field outputs equal the fuse contents, so any bit that could not be burned reads back as the fuse value.
- R8: A digital read (cmd_op = 2) returns the fuse word on rsp_data, bit i of the reply being fuse bit i. rsp_valid stays high with stable data until rsp_ready is seen.
- R9: A readback (cmd_op = 3) sends 46 bits on rb_bit, fuse bit 45 first and bit 0 last, one bit per handshake. rb_last is high only with bit 0. Under back-pressure, rb_valid, rb_bit and rb_last hold steady.
- R10: While busy is high, cmd_ready is low. A request presented during that time is never taken and produces no reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted this cycle when valid |
| cmd_op | input | 2 | 0 write, 1 program, 2 read, 3 readback |
| cmd_wdata | input | 46 | Write data for the shadow |
| rsp_valid | output | 1 | Read reply present |
| rsp_ready | input | 1 | Reply consumer ready |
| rsp_data | output | 46 | Fuse word returned by a read |
| rb_valid | output | 1 | Readback bit present |
| rb_ready | input | 1 | Readback consumer ready |
| rb_bit | output | 1 | Current readback bit |
| rb_last | output | 1 | Marks bit 0, the final bit |
| busy | output | 1 | Load, burn, reply or readback in progress |
| fuse_q | input | 46 | Present state of the fuse array |
| burn_pulse | output | 1 | Burn the fuse at burn_idx for this clock |
| burn_idx | output | 6 | Index of the fuse to burn |
| hall_bias | output | 6 | Hall bias field |
| offset_hi | output | 1 | Output DC offset select |
| pga_gain | output | 2 | Amplifier gain field |
| cm_cos_en | output | 1 | Common-mode output on cosine pin |
| cm_sin_en | output | 1 | Common-mode output on sine pin |
| chan_invert | output | 1 | Channel inversion |

## Verification
The assertions take three things for granted about the inputs. First, the fuse state changes only in response to burn pulses, and only upward. Second, a burn is applied within the cycle of its pulse. Third, the reply and readback consumers follow ordinary valid/ready rules. The stimulus keeps to these by driving the fuse input from a behavioural array. That array is seeded only while reset is held, and afterwards it sets one bit at the falling edge inside each pulse cycle. Requests are issued only when the block is idle, except for deliberate requests presented during a burn. The ready signals toggle in fixed patterns to exercise stalls.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int OTP_W     = 46;
  localparam int FACT_LSB  = 16;
  localparam int PROT_LSB  = 14;
  localparam int LOCK_POS  = 13;

  localparam int USER_W    = 12;
  localparam int HB_LSB    = 0;
  localparam int HB_W      = 6;
  localparam int OFS_POS   = 6;
  localparam int GAIN_LSB  = 7;
  localparam int GAIN_W    = 2;
  localparam int CMCOS_POS = 9;
  localparam int CMSIN_POS = 10;
  localparam int INV_POS   = 11;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_READ    = 2'd2,
    OP_STREAM  = 2'd3
  } otp_op_e;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_IDLE,
    ST_BURN,
    ST_RELOAD,
    ST_REPLY,
    ST_STREAM
  } ctl_state_e;

endpackage

// File: rtl/otp_access_mask.sv
module otp_access_mask #(
  parameter int W        = 46,
  parameter int PROT_LSB = 14,
  parameter int FACT_LSB = 16
) (
  input  logic         locked,
  output logic [W-1:0] allow
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b < PROT_LSB) begin : g_user
      assign allow[b] = 1'b1;
    end else if (b < FACT_LSB) begin : g_prot
      assign allow[b] = ~locked;
    end else begin : g_fact
      assign allow[b] = 1'b0;
    end
  end

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int W = 46,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  mask,
  output logic          pulse,
  output logic [IW-1:0] idx,
  output logic          last
);

  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  logic          active_q;
  logic [W-1:0]  mask_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mask_q   <= '0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      mask_q   <= mask;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == TOP_IDX) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign pulse = active_q & mask_q[idx_q];
  assign idx   = idx_q;
  assign last  = active_q && (idx_q == TOP_IDX);

endmodule

// File: rtl/otp_bit_stream.sv
module otp_bit_stream #(
  parameter int W = 46,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         ready,
  output logic         valid,
  output logic         bit_o,
  output logic         last,
  output logic         done
);

  logic          active_q;
  logic [W-1:0]  word_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      word_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      word_q   <= word;
      cnt_q    <= IW'(W - 1);
    end else if (active_q && ready) begin
      if (cnt_q == '0) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign valid = active_q;
  assign bit_o = word_q[cnt_q];
  assign last  = active_q && (cnt_q == '0);
  assign done  = last && ready;

endmodule

// File: rtl/otp_field_map.sv
module otp_field_map
  import otp_pkg::*;
#(
  parameter int UW = USER_W
) (
  input  logic [UW-1:0]     user,
  output logic [HB_W-1:0]   hall_bias,
  output logic              offset_hi,
  output logic [GAIN_W-1:0] pga_gain,
  output logic              cm_cos_en,
  output logic              cm_sin_en,
  output logic              chan_invert
);

  assign hall_bias   = user[HB_LSB +: HB_W];
  assign offset_hi   = user[OFS_POS];
  assign pga_gain    = user[GAIN_LSB +: GAIN_W];
  assign cm_cos_en   = user[CMCOS_POS];
  assign cm_sin_en   = user[CMSIN_POS];
  assign chan_invert = user[INV_POS];

endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_pkg::*;
#(
  parameter int W         = OTP_W,
  parameter int FACT_BASE = FACT_LSB,
  parameter int PROT_BASE = PROT_LSB,
  parameter int LOCK_BIT  = LOCK_POS,
  localparam int IW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [W-1:0]      cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_data,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic              rb_bit,
  output logic              rb_last,
  output logic              busy,
  input  logic [W-1:0]      fuse_q,
  output logic              burn_pulse,
  output logic [IW-1:0]     burn_idx,
  output logic [HB_W-1:0]   hall_bias,
  output logic              offset_hi,
  output logic [GAIN_W-1:0] pga_gain,
  output logic              cm_cos_en,
  output logic              cm_sin_en,
  output logic              chan_invert
);

  ctl_state_e   st_q;
  logic [W-1:0] shadow_q;
  logic [W-1:0] reply_q;

  logic         accept;
  otp_op_e      op;
  logic         lock_fuse;
  logic         lock_prog;
  logic [W-1:0] allow_wr;
  logic [W-1:0] allow_pg;
  logic [W-1:0] burn_mask;
  logic         burn_start;
  logic         burn_last;
  logic         stream_start;
  logic         stream_done;

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign op        = otp_op_e'(cmd_op);

  // Lock for edits comes from the fuses; a program that sets the lock
  // also protects its neighbours within the same run.
  assign lock_fuse = fuse_q[LOCK_BIT];
  assign lock_prog = fuse_q[LOCK_BIT] | shadow_q[LOCK_BIT];

  otp_access_mask #(
    .W(W), .PROT_LSB(PROT_BASE), .FACT_LSB(FACT_BASE)
  ) u_mask_wr (
    .locked (lock_fuse),
    .allow  (allow_wr)
  );

  otp_access_mask #(
    .W(W), .PROT_LSB(PROT_BASE), .FACT_LSB(FACT_BASE)
  ) u_mask_pg (
    .locked (lock_prog),
    .allow  (allow_pg)
  );

  assign burn_mask    = shadow_q & ~fuse_q & allow_pg;
  assign burn_start   = accept && (op == OP_PROGRAM);
  assign stream_start = accept && (op == OP_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_LOAD;
      shadow_q <= '0;
      reply_q  <= '0;
    end else begin
      case (st_q)
        ST_LOAD: begin
          shadow_q <= fuse_q;
          st_q     <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            case (op)
              OP_WRITE:   shadow_q <= (shadow_q & ~allow_wr) | (cmd_wdata & allow_wr);
              OP_PROGRAM: st_q <= ST_BURN;
              OP_READ: begin
                reply_q <= fuse_q;
                st_q    <= ST_REPLY;
              end
              default:    st_q <= ST_STREAM;
            endcase
          end
        end
        ST_BURN: begin
          if (burn_last) st_q <= ST_RELOAD;
        end
        ST_RELOAD: begin
          shadow_q <= fuse_q;
          st_q     <= ST_IDLE;
        end
        ST_REPLY: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        ST_STREAM: begin
          if (stream_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  otp_burn_seq #(.W(W)) u_burn (
    .clk   (clk),
    .rst_n (rst_n),
    .start (burn_start),
    .mask  (burn_mask),
    .pulse (burn_pulse),
    .idx   (burn_idx),
    .last  (burn_last)
  );

  otp_bit_stream #(.W(W)) u_stream (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stream_start),
    .word  (fuse_q),
    .ready (rb_ready),
    .valid (rb_valid),
    .bit_o (rb_bit),
    .last  (rb_last),
    .done  (stream_done)
  );

  assign rsp_valid = (st_q == ST_REPLY);
  assign rsp_data  = reply_q;

  otp_field_map u_fields (
    .user        (shadow_q[USER_W-1:0]),
    .hall_bias   (hall_bias),
    .offset_hi   (offset_hi),
    .pga_gain    (pga_gain),
    .cm_cos_en   (cm_cos_en),
    .cm_sin_en   (cm_sin_en),
    .chan_invert (chan_invert)
  );

endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
module otp_shadow_ctrl_chk #(
  parameter int W         = 46,
  parameter int FACT_BASE = 16,
  parameter int PROT_BASE = 14,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          busy,
  input logic          burn_pulse,
  input logic [IW-1:0] burn_idx,
  input logic          lock_fuse,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [W-1:0]  rsp_data,
  input logic          rb_valid,
  input logic          rb_ready,
  input logic          rb_bit,
  input logic          rb_last
);

  assert_pulse_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burn_pulse |=> !(burn_pulse && burn_idx == $past(burn_idx)));

  assert_no_factory_burn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burn_pulse |-> (int'(burn_idx) < FACT_BASE));

  assert_lock_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_pulse && lock_fuse) |-> (int'(burn_idx) < PROT_BASE));

  assert_reply_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_bit) && $stable(rb_last)));

  assert_burn_blocks_cmds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burn_pulse |-> (busy && !cmd_ready));

  assert_stream_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> (busy && !cmd_ready));

endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(
  .W(W), .FACT_BASE(FACT_BASE), .PROT_BASE(PROT_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .burn_pulse (burn_pulse),
  .burn_idx   (burn_idx),
  .lock_fuse  (fuse_q[LOCK_BIT]),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rb_valid   (rb_valid),
  .rb_ready   (rb_ready),
  .rb_bit     (rb_bit),
  .rb_last    (rb_last)
);

// File: tb/otp_shadow_ctrl_test.sv
module otp_shadow_ctrl_test;

  localparam int W  = 46;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [W-1:0]  cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [W-1:0]  rsp_data;
  logic          rb_valid;
  logic          rb_ready = 1'b0;
  logic          rb_bit;
  logic          rb_last;
  logic          busy;
  logic [W-1:0]  fuse = '0;
  logic          burn_pulse;
  logic [IW-1:0] burn_idx;
  logic [5:0]    hall_bias;
  logic          offset_hi;
  logic [1:0]    pga_gain;
  logic          cm_cos_en, cm_sin_en, chan_invert;

  logic          fuse_load = 1'b0;
  logic [W-1:0]  fuse_seed = '0;
  logic [W-1:0]  pulse_set = '0;
  int            pulse_cnt = 0;
  int            order_bad = 0;
  int            last_idx = -1;
  int            errors = 0;
  int            checks = 0;
  bit            finished = 0;
  logic [W-1:0]  ef;
  logic [W-1:0]  factory = {30'h1B6D52E3, 16'h0204};

  always #4 clk = ~clk;

  otp_shadow_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .rb_bit(rb_bit), .rb_last(rb_last), .busy(busy),
    .fuse_q(fuse), .burn_pulse(burn_pulse), .burn_idx(burn_idx),
    .hall_bias(hall_bias), .offset_hi(offset_hi), .pga_gain(pga_gain),
    .cm_cos_en(cm_cos_en), .cm_sin_en(cm_sin_en), .chan_invert(chan_invert)
  );

  // Behavioural fuse array: applies a burn inside the pulse cycle, away from the rising edge.
  always @(negedge clk) begin
    if (fuse_load) begin
      fuse = fuse_seed;
    end else if (burn_pulse) begin
      if (pulse_cnt > 0 && int'(burn_idx) <= last_idx) order_bad++;
      pulse_set[burn_idx] = 1'b1;
      pulse_cnt++;
      last_idx = int'(burn_idx);
      fuse[burn_idx] = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] allow_of(input logic locked);
    return locked ? 46'h3FFF : 46'hFFFF;
  endfunction

  function automatic logic [11:0] fields();
    return {chan_invert, cm_sin_en, cm_cos_en, pga_gain, offset_hi, hall_bias};
  endfunction

  task automatic reset_with(input logic [W-1:0] seed);
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; rsp_ready = 1'b0; rb_ready = 1'b0;
    fuse_seed = seed; fuse_load = 1'b1;
    repeat (2) @(negedge clk);
    fuse_load = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic read_fuse(output logic [W-1:0] v);
    send(2'd2, '0);
    @(negedge clk);
    chk("R8 reply valid", {45'd0, rsp_valid}, 46'd1);
    v = rsp_data;
    @(negedge clk);
    chk("R8 reply held under stall", {rsp_valid, rsp_data[W-2:0]}, {1'b1, v[W-2:0]});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 reply released", {45'd0, rsp_valid}, 46'd0);
  endtask

  task automatic run_program(input bit inject, output int bc);
    pulse_set = '0; pulse_cnt = 0; order_bad = 0; last_idx = -1;
    send(2'd1, '0);
    bc = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (inject && k == 0) begin cmd_valid = 1'b1; cmd_op = 2'd2; end
      if (inject && k >= 1 && k <= 3) chk("R10 ready low while busy", {45'd0, cmd_ready}, 46'd0);
      if (k == 4) cmd_valid = 1'b0;
      if (!busy) break;
      bc++;
    end
  endtask

  task automatic prog_case(input logic [15:0] low, input bit inject);
    logic [W-1:0] p, a, sh, ex, v;
    int bc;
    p  = {{(W-16){1'b1}}, low};
    a  = allow_of(ef[13]);
    sh = (ef & ~a) | (p & a);
    ex = sh & ~ef & allow_of(ef[13] | sh[13]);
    send(2'd0, p);
    run_program(inject, bc);
    chk("R4 burned set", pulse_set, ex);
    chk("R4 pulse count", W'(pulse_cnt), W'($countones(ex)));
    chk("R4 ascending order", W'(order_bad), '0);
    chk("R7 busy length", W'(bc), W'(W + 1));
    if (inject) begin
      repeat (3) begin
        @(negedge clk);
        chk("R10 rejected request gave no reply", {45'd0, rsp_valid}, 46'd0);
      end
    end
    ef = ef | ex;
    @(negedge clk);
    chk("R7 fields follow fuses", {34'd0, fields()}, {34'd0, ef[11:0]});
    read_fuse(v);
    chk("R7 read after program", v, ef);
    chk("R5 factory bits unchanged", {16'd0, v[W-1:16]}, {16'd0, factory[W-1:16]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R10 act=hung exp=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] got;
    int n, cyc, lastbad;

    // R1: reset state and load from fuses
    reset_with(factory);
    ef = factory;
    chk("R1 busy low", {45'd0, busy}, 46'd0);
    chk("R1 ready high", {45'd0, cmd_ready}, 46'd1);
    chk("R1 idle outputs", {43'd0, burn_pulse, rsp_valid, rb_valid}, 46'd0);
    chk("R1 R2 fields from fuses", {34'd0, fields()}, {34'd0, factory[11:0]});

    read_fuse(v);
    chk("R8 read returns fuse word", v, factory);

    // R2, R3: exhaustive sweep of writable low bits
    for (int i = 0; i < 16384; i++) begin
      send(2'd0, {{(W-16){1'b1}}, 2'b11, 14'(i)});
      @(negedge clk);
      chk("R2 R3 field decode after write", {34'd0, fields()}, {34'd0, 12'(i)});
    end
    read_fuse(v);
    chk("R3 writes burn nothing", v, factory);

    // R9: serial readback with back-pressure
    send(2'd3, '0);
    got = '0; n = 0; cyc = 0; lastbad = 0;
    while (n < W && cyc < 400) begin
      @(negedge clk);
      cyc++;
      rb_ready = (cyc % 3) != 0;
      if (rb_valid && rb_ready) begin
        got = {got[W-2:0], rb_bit};
        if (rb_last !== (n == W - 1)) lastbad++;
        n++;
      end
    end
    @(negedge clk);
    rb_ready = 1'b0;
    chk("R9 bits msb first", got, factory);
    chk("R9 bit count", W'(n), W'(W));
    chk("R9 last marker", W'(lastbad), '0);
    chk("R9 stream ends", {44'd0, rb_valid, busy}, 46'd0);

    // R4, R5, R7, R10: program with a blocked request during the burn
    reset_with(factory);
    ef = factory;
    prog_case(16'hC2A5, 1'b1);
    // R4: nothing new to burn
    prog_case(16'hC2A5, 1'b0);

    // R6: lock set by the same program, then lock from fuses
    reset_with(factory);
    ef = factory;
    prog_case(16'hE010, 1'b0);
    prog_case(16'hC008, 1'b0);
    read_fuse(v);
    chk("R6 protected bits not burned", {44'd0, v[15:14]}, 46'd0);
    chk("R6 lock burned", {45'd0, v[13]}, 46'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule